// File: doc/BRIEF.md
# Single-Precision to 16-bit Float Narrowing Converter

This block narrows one IEEE single-precision value per cycle into a 16-bit floating-point word. A per-sample mode bit picks the target. In brain-float mode the 8-bit exponent passes through unchanged and only the fraction is shortened. In half-precision mode the exponent is re-biased into a 5-bit field, which can overflow or underflow. Both targets round to nearest with ties to even.

The result appears on a registered output one cycle after it is accepted, together with a valid strobe. Two status flags mark results that lost range: overflow means a finite input became infinity, and underflow means a nonzero input ended below the normal range. The block is meant to sit on a weight or activation path where fp32 values are packed into 16-bit storage. The mode can change from one sample to the next.

Top module: `f32_narrower`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs `out_valid`, `out_data`, `out_ovf` and `out_unf` are all cleared to zero, even if `in_valid` is high.
- R2: Each cycle with `in_valid` high produces exactly one cycle of `out_valid` on the following clock edge, with no extra strobes. Back-to-back inputs with mixed modes are all accepted.
- R3: With `in_to_half` = 0 (brain-float), the output is {sign, input bits 30:23, 7-bit fraction}. The fraction is the top 7 input fraction bits rounded to nearest-even on the 16 dropped bits. For example, 0x3F80A3D7 gives 0x3F81 and the tie 0x3F808000 stays at 0x3F80.
- R4: With `in_to_half` = 1 (half), a normal result is {sign, 5-bit exponent = input exponent − 112, 10-bit fraction}, rounded to nearest-even on the 13 dropped bits. For example, 0x3F80A3D7 gives 0x3C05 and 0x477FE000 gives 0x7BFF (65504).
- R5: In half mode, a finite input whose rounded magnitude exceeds 65504 gives signed infinity (0x7C00 or 0xFC00) and sets `out_ovf`. 1e5 and 1e10 both give 0x7C00.
- R6: In brain-float mode, a rounding carry out of the fraction increments the exponent (0x3FFF8000 gives 0x4000). A carry out of the largest finite value gives signed infinity (0x7F80 or 0xFF80) and sets `out_ovf`.
- R7: In half mode, a nonzero input whose rounded magnitude is below 2^-14 is flushed to signed zero and sets `out_unf`. For example, 1e-7 (0x33D6BF95) gives 0x0000. An input that rounds up to exactly 2^-14 gives 0x0400 with no flag.
- R8: In brain-float mode, small values keep their value (1e-7 gives 0x33D7). A nonzero input whose result has an exponent field of zero, whether zero or subnormal, sets `out_unf`.
- R9: A NaN input gives a quiet NaN with the same sign: the exponent field is all ones, the top fraction bit is set, and the lower fraction bits carry the next input fraction bits. Brain-float gives {s, 0xFF, 1, in[21:16]}; half gives {s, 0x1F, 1, in[21:13]}. No flag is set.
- R10: Infinity inputs give infinity of the same sign, and zero inputs give zero of the same sign, in both modes with no flag.
- R11: `out_ovf` and `out_unf` are never both set, and the output sign always equals the input sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_data | input | 32 | Single-precision input value |
| in_to_half | input | 1 | Target select: 0 brain-float, 1 half precision |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 16 | Narrowed 16-bit result |
| out_ovf | output | 1 | Finite input became infinity |
| out_unf | output | 1 | Nonzero input ended below the normal range |

## Verification
The path has a single register stage, so any fault in the rounding, re-bias or special-value decode shows up on `out_data` in the cycle right after the sample. It usually shows as a one-ULP error, a wrong exponent field, or a lost quiet bit. A wrong range decision shows in that same cycle as a flag that disagrees with an infinite or zero pattern. The stimulus therefore concentrates on the points where one bit of input changes the outcome: exact ties, carries across the exponent, the 65504 limit and the 2^-14 boundary. A fault in the strobe path shows as a missing or extra `out_valid`, which the scoreboard catches at once.

// File: rtl/narrow_pkg.sv
package narrow_pkg;
  localparam int SRC_W     = 32;
  localparam int SRC_EW    = 8;
  localparam int SRC_MW    = 23;
  localparam int SRC_BIAS  = 127;
  localparam int DST_W     = 16;
  localparam int HF_EW     = 5;
  localparam int HF_MW     = 10;
  localparam int HF_BIAS   = 15;
  localparam int BF_MW     = 7;
  localparam int BF_DROP   = SRC_MW - BF_MW;
  localparam int HF_DROP   = SRC_MW - HF_MW;
  localparam int HF_REBIAS = SRC_BIAS - HF_BIAS;
  localparam int HF_EMAX   = (1 << HF_EW) - 1;

  typedef struct packed {
    logic [DST_W-1:0] bits;
    logic             ovf;
    logic             unf;
  } narrow_res_t;

  // round to nearest, ties to even
  function automatic logic rne_up(input logic lsb, input logic guard, input logic sticky);
    return guard & (sticky | lsb);
  endfunction
endpackage

// File: rtl/narrow_bf16.sv
module narrow_bf16
  import narrow_pkg::*;
(
  input  logic [SRC_W-1:0] src,
  output narrow_res_t      res
);
  localparam int KW = SRC_EW + BF_MW;

  logic              sgn;
  logic [SRC_EW-1:0] ex;
  logic [SRC_MW-1:0] man;
  logic [KW-1:0]     kept;
  logic [KW-1:0]     rsum;
  logic              up;

  assign sgn  = src[SRC_W-1];
  assign ex   = src[SRC_W-2 -: SRC_EW];
  assign man  = src[SRC_MW-1:0];
  assign kept = src[SRC_W-2 -: KW];
  assign up   = rne_up(man[BF_DROP], man[BF_DROP-1], |man[BF_DROP-2:0]);
  assign rsum = kept + {{(KW-1){1'b0}}, up};

  always_comb begin
    res = '0;
    res.bits[DST_W-1] = sgn;
    if (&ex) begin
      if (|man) res.bits[DST_W-2:0] = {ex, 1'b1, man[SRC_MW-2 -: BF_MW-1]};
      else      res.bits[DST_W-2:0] = {ex, {BF_MW{1'b0}}};
    end else begin
      res.bits[DST_W-2:0] = rsum;
      res.ovf = &rsum[KW-1 -: SRC_EW];
      res.unf = (|src[SRC_W-2:0]) && !(|rsum[KW-1 -: SRC_EW]);
    end
  end
endmodule

// File: rtl/narrow_half.sv
module narrow_half
  import narrow_pkg::*;
(
  input  logic [SRC_W-1:0] src,
  output narrow_res_t      res
);
  localparam int KW = HF_EW + HF_MW;
  localparam logic [SRC_EW-1:0] EX_LOW  = SRC_EW'(HF_REBIAS);
  localparam logic [SRC_EW-1:0] EX_HIGH = SRC_EW'(HF_REBIAS + HF_EMAX);

  logic              sgn;
  logic [SRC_EW-1:0] ex;
  logic [SRC_MW-1:0] man;
  logic [HF_MW-1:0]  hm;
  logic [HF_EW-1:0]  hexp;
  logic [KW-1:0]     nsum;
  logic              up;

  assign sgn  = src[SRC_W-1];
  assign ex   = src[SRC_W-2 -: SRC_EW];
  assign man  = src[SRC_MW-1:0];
  assign hm   = man[SRC_MW-1 -: HF_MW];
  assign hexp = HF_EW'(ex - EX_LOW);
  assign up   = rne_up(man[HF_DROP], man[HF_DROP-1], |man[HF_DROP-2:0]);
  assign nsum = {hexp, hm} + {{(KW-1){1'b0}}, up};

  always_comb begin
    res = '0;
    res.bits[DST_W-1] = sgn;
    if (&ex) begin
      if (|man) res.bits[KW-1:0] = {{HF_EW{1'b1}}, 1'b1, man[SRC_MW-2 -: HF_MW-1]};
      else      res.bits[KW-1:0] = {{HF_EW{1'b1}}, {HF_MW{1'b0}}};
    end else if (ex == '0) begin
      res.unf = |man;
    end else if (ex >= EX_HIGH) begin
      res.bits[KW-1:0] = {{HF_EW{1'b1}}, {HF_MW{1'b0}}};
      res.ovf = 1'b1;
    end else if (ex > EX_LOW) begin
      res.bits[KW-1:0] = nsum;
      res.ovf = &nsum[KW-1 -: HF_EW];
    end else if (ex == EX_LOW && (&hm) && up) begin
      res.bits[KW-1:0] = {{(HF_EW-1){1'b0}}, 1'b1, {HF_MW{1'b0}}};
    end else begin
      res.unf = 1'b1;
    end
  end
endmodule

// File: rtl/f32_narrower.sv
module f32_narrower
  import narrow_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [SRC_W-1:0] in_data,
  input  logic             in_to_half,
  output logic             out_valid,
  output logic [DST_W-1:0] out_data,
  output logic             out_ovf,
  output logic             out_unf
);
  narrow_res_t bf_res;
  narrow_res_t hf_res;
  narrow_res_t pick;

  narrow_bf16 u_bf (.src(in_data), .res(bf_res));
  narrow_half u_hf (.src(in_data), .res(hf_res));

  assign pick = in_to_half ? hf_res : bf_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ovf   <= 1'b0;
      out_unf   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= pick.bits;
        out_ovf  <= pick.ovf;
        out_unf  <= pick.unf;
      end
    end
  end
endmodule

// File: rtl/f32_narrower_chk.sv
module f32_narrower_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        src_sgn,
  input logic [7:0]  src_exp,
  input logic        in_to_half,
  input logic        out_valid,
  input logic [15:0] out_data,
  input logic        out_ovf,
  input logic        out_unf
);
  assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_no_stray_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_ovf && out_unf));
  assert_sign_kept_R11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_data[15] == $past(src_sgn)));
  assert_half_ovf_is_inf_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_to_half) |=> (!out_ovf || out_data[14:0] == 15'h7C00));
  assert_bf_ovf_is_inf_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_to_half) |=> (!out_ovf || out_data[14:0] == 15'h7F80));
  assert_half_unf_is_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_to_half) |=> (!out_unf || out_data[14:0] == 15'h0000));
  assert_bf_exp_kept_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_to_half && src_exp != 8'h00 && src_exp != 8'hFF) |=>
      (out_data[14:7] == $past(src_exp) || out_data[14:7] == $past(src_exp) + 8'd1));
  assert_special_no_flags_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && src_exp == 8'hFF) |=> (!out_ovf && !out_unf));
endmodule

bind f32_narrower f32_narrower_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .src_sgn(in_data[31]),
  .src_exp(in_data[30:23]), .in_to_half(in_to_half), .out_valid(out_valid),
  .out_data(out_data), .out_ovf(out_ovf), .out_unf(out_unf)
);

// File: tb/f32_narrower_test.sv
`timescale 1ns/1ps
module f32_narrower_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_to_half = 1'b0;
  logic        out_valid;
  logic [15:0] out_data;
  logic        out_ovf;
  logic        out_unf;

  int tests = 0;
  int fails = 0;
  int pushed = 0;
  int seen = 0;
  bit done = 1'b0;

  logic [17:0] q_exp[$];
  string       q_tag[$];
  logic [31:0] q_src[$];

  f32_narrower uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_to_half(in_to_half), .out_valid(out_valid), .out_data(out_data),
    .out_ovf(out_ovf), .out_unf(out_unf)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] v, input logic half, input logic [15:0] eb,
                       input logic eo, input logic eu, input string tag);
    q_exp.push_back({eb, eo, eu});
    q_tag.push_back(tag);
    q_src.push_back(v);
    pushed++;
    in_data = v;
    in_to_half = half;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      seen++;
      if (q_exp.size() == 0) begin
        check(1'b0, "R2 stray strobe", {16'h0, out_data}, 32'h0);
      end else begin
        logic [17:0] e;
        string t;
        logic [31:0] s;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        s = q_src.pop_front();
        check({out_data, out_ovf, out_unf} == e, $sformatf("%s src=%h {data,ovf,unf}", t, s),
              {14'h0, out_data, out_ovf, out_unf}, {14'h0, e});
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset dominates an active input
    in_valid = 1'b1;
    in_data = 32'h3F800000;
    repeat (3) @(negedge clk);
    check(out_valid == 0 && out_data == 0 && out_ovf == 0 && out_unf == 0, "R1 outputs in reset",
          {13'h0, out_valid, out_data, out_ovf, out_unf}, 32'h0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 0, "R1 idle after reset", {31'h0, out_valid}, 32'h0);

    // R3 brain-float rounding
    drive(32'h3F80A3D7, 1'b0, 16'h3F81, 0, 0, "R3 1.005");
    drive(32'h3F808000, 1'b0, 16'h3F80, 0, 0, "R3 tie to even down");
    drive(32'h3F818000, 1'b0, 16'h3F82, 0, 0, "R3 tie to even up");
    drive(32'hC0000000, 1'b0, 16'hC000, 0, 0, "R3 negative exact");
    // R4 half normal range (back-to-back, mixed modes also exercise R2)
    drive(32'h3F80A3D7, 1'b1, 16'h3C05, 0, 0, "R4 1.005");
    drive(32'h3F801000, 1'b1, 16'h3C00, 0, 0, "R4 tie to even down");
    drive(32'h3F803000, 1'b1, 16'h3C02, 0, 0, "R4 tie to even up");
    drive(32'h477FE000, 1'b1, 16'h7BFF, 0, 0, "R4 largest finite");
    drive(32'h38800000, 1'b1, 16'h0400, 0, 0, "R4 smallest normal");
    // R5 half overflow
    drive(32'h477FF000, 1'b1, 16'h7C00, 1, 0, "R5 rounds past 65504");
    drive(32'h47C35000, 1'b1, 16'h7C00, 1, 0, "R5 1e5");
    drive(32'h501502F9, 1'b1, 16'h7C00, 1, 0, "R5 1e10");
    drive(32'hC7C35000, 1'b1, 16'hFC00, 1, 0, "R5 -1e5");
    repeat (3) @(negedge clk);  // gap: R2 no stray strobe
    // R6 brain-float carry
    drive(32'h3FFF8000, 1'b0, 16'h4000, 0, 0, "R6 carry into exponent");
    drive(32'h7F7FFFFF, 1'b0, 16'h7F80, 1, 0, "R6 carry to +inf");
    drive(32'hFF7FFFFF, 1'b0, 16'hFF80, 1, 0, "R6 carry to -inf");
    drive(32'h7F7F7FFF, 1'b0, 16'h7F7F, 0, 0, "R6 max stays finite");
    // R7 half underflow
    drive(32'h33D6BF95, 1'b1, 16'h0000, 0, 1, "R7 1e-7 flushed");
    drive(32'hB3D6BF95, 1'b1, 16'h8000, 0, 1, "R7 -1e-7 flushed");
    drive(32'h387FF000, 1'b1, 16'h0400, 0, 0, "R7 rounds up to min normal");
    drive(32'h387FE000, 1'b1, 16'h0000, 0, 1, "R7 just below min normal");
    drive(32'h00000001, 1'b1, 16'h0000, 0, 1, "R7 fp32 subnormal");
    // R8 brain-float small values
    drive(32'h33D6BF95, 1'b0, 16'h33D7, 0, 0, "R8 1e-7 kept");
    drive(32'h00400000, 1'b0, 16'h0040, 0, 1, "R8 subnormal result");
    drive(32'h00000001, 1'b0, 16'h0000, 0, 1, "R8 rounds to zero");
    drive(32'h007FFFFF, 1'b0, 16'h0080, 0, 0, "R8 rounds up to normal");
    // R9 NaN
    drive(32'h7FC00000, 1'b0, 16'h7FC0, 0, 0, "R9 quiet NaN bf");
    drive(32'h7FC00000, 1'b1, 16'h7E00, 0, 0, "R9 quiet NaN half");
    drive(32'hFF800001, 1'b0, 16'hFFC0, 0, 0, "R9 signalling NaN bf");
    drive(32'hFF800001, 1'b1, 16'hFE00, 0, 0, "R9 signalling NaN half");
    drive(32'h7FA12345, 1'b0, 16'h7FE1, 0, 0, "R9 payload bf");
    drive(32'h7FA12345, 1'b1, 16'h7F09, 0, 0, "R9 payload half");
    // R10 infinities and zeros; R11 flags exclusive throughout
    drive(32'h7F800000, 1'b1, 16'h7C00, 0, 0, "R10 +inf half");
    drive(32'hFF800000, 1'b0, 16'hFF80, 0, 0, "R10 -inf bf");
    drive(32'h80000000, 1'b1, 16'h8000, 0, 0, "R10 -0 half");
    drive(32'h80000000, 1'b0, 16'h8000, 0, 0, "R11 -0 bf sign kept");

    repeat (4) @(negedge clk);
    check(seen == pushed && q_exp.size() == 0, "R2 one result per input",
          32'(seen), 32'(pushed));
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule